// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the processor-side register front end of a display controller. A narrow byte bus carries an I/O address, a write strobe, a read strobe and a data byte. The block decodes five I/O addresses. Three of them serve the colour lookup table: the table mode and read index, the write index, and the colour data. The other two serve the CRT timing register file: an index and a data port.

Colour data is stored as three bytes per entry. The same data port is used for every colour component, and a small component counter steps through the three bytes. After the third byte, the active entry index moves on by one. The CRT timing registers are held in a flat array, and the whole array is driven out in parallel to the timing logic downstream.

A lock bit in CRT register 0x11 protects the lowest eight timing registers from software writes. One field of register 7 stays writable while the lock is set.

Top module: `disp_reg_port`

## Requirements
- R1: After reset, the colour read index, the colour write index, the component counter, the table mode, the CRT index and every CRT register are zero. Colour table contents are not cleared.
- R2: A read of address 0x3C7 returns the table mode. Writing a start index to 0x3C7 sets the mode to 0x03. Writing a start index to 0x3C8 sets the mode to 0x00.
- R3: A read of 0x3C8 returns the colour write index. Writing 0x3C8 loads that index and clears the component counter. The index advances by one after every third data write and wraps from 255 to 0.
- R4: A write to 0x3C9 stores the byte at table byte address write_index*3 + component, then steps the component counter.
- R5: A read of 0x3C9 returns the byte at read_index*3 + component and steps the counter. After the third component, the counter returns to 0 and the read index advances by one, wrapping from 255 to 0. Writing 0x3C7 loads the read index and clears the counter.
- R6: A write to 0x3D4 sets the CRT index. A read of 0x3D4 returns that index, and a read of 0x3D5 returns the register it selects.
- R7: When bit 7 of CRT register 0x11 is clear, or the index is 8 or above, a write to 0x3D5 stores the byte unchanged.
- R8: When bit 7 of CRT register 0x11 is set, writes to CRT registers 0 to 6 leave them unchanged.
- R9: When the lock is set, a write to CRT register 7 replaces only bit 4 of that register and keeps its other seven bits.
- R10: When the CRT index is at or beyond the register count, writes through 0x3D5 change no register and reads of 0x3D5 return 0.
- R11: The crtRegs output carries register n on bits n*8+7 down to n*8.
- R12: With the read strobe low, or at any undecoded address, the read data is 0. Accesses to undecoded addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | I/O address of the access |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe; a read has side effects at the clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the same cycle as busRd |
| crtRegs | output | CRT_COUNT*8 | Flattened CRT register array |

## Verification
The bench uses the default build: ten address bits, 32 CRT registers and 256 colour entries. With 32 registers, index 0x30 lies past the array, so the out-of-range path of R10 can be reached from the bus. With 256 entries, loading index 255 brings both index wraps within one entry's three accesses, and both wraps can be checked by reading back entry 0.

// File: rtl/disp_reg_port_pkg.sv
package disp_reg_port_pkg;

  localparam int PORT_DAC_MODE = 'h3C7;
  localparam int PORT_DAC_WIDX = 'h3C8;
  localparam int PORT_DAC_DATA = 'h3C9;
  localparam int PORT_CRT_IDX  = 'h3D4;
  localparam int PORT_CRT_DATA = 'h3D5;

  localparam int LOCK_REG  = 'h11;
  localparam int LOCK_BIT  = 7;
  localparam int PROT_LAST = 7;
  localparam int KEEP_BIT  = 4;
  localparam logic [7:0] MODE_READING = 8'h03;
  localparam logic [7:0] MODE_WRITING = 8'h00;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DAC_MODE,
    RD_DAC_WIDX,
    RD_PAL,
    RD_CRT_IDX,
    RD_CRT_DATA
  } rdSel_e;

  typedef struct packed {
    logic   loadRdIdx;
    logic   loadWrIdx;
    logic   palWr;
    logic   palRd;
    logic   crtIdxWr;
    logic   crtDataWr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/disp_reg_port_ctrl.sv
module disp_reg_port_ctrl
  import disp_reg_port_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          stb
);

  logic hitMode, hitWidx, hitData, hitCrtIdx, hitCrtData, doRd;

  assign hitMode    = (busAddr == ADDR_W'(PORT_DAC_MODE));
  assign hitWidx    = (busAddr == ADDR_W'(PORT_DAC_WIDX));
  assign hitData    = (busAddr == ADDR_W'(PORT_DAC_DATA));
  assign hitCrtIdx  = (busAddr == ADDR_W'(PORT_CRT_IDX));
  assign hitCrtData = (busAddr == ADDR_W'(PORT_CRT_DATA));

  // a write takes the cycle; a simultaneous read is dropped
  assign doRd = busRd && !busWr;

  always_comb begin
    stb           = '0;
    stb.rdSel     = RD_NONE;
    stb.loadRdIdx = busWr && hitMode;
    stb.loadWrIdx = busWr && hitWidx;
    stb.palWr     = busWr && hitData;
    stb.crtIdxWr  = busWr && hitCrtIdx;
    stb.crtDataWr = busWr && hitCrtData;
    stb.palRd     = doRd && hitData;
    if (doRd) begin
      if (hitMode)         stb.rdSel = RD_DAC_MODE;
      else if (hitWidx)    stb.rdSel = RD_DAC_WIDX;
      else if (hitData)    stb.rdSel = RD_PAL;
      else if (hitCrtIdx)  stb.rdSel = RD_CRT_IDX;
      else if (hitCrtData) stb.rdSel = RD_CRT_DATA;
    end
  end

endmodule

// File: rtl/disp_reg_port_dpath.sv
module disp_reg_port_dpath
  import disp_reg_port_pkg::*;
#(
  parameter int CRT_COUNT   = 32,
  parameter int PAL_ENTRIES = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [CRT_COUNT*8-1:0] crtRegs
);

  localparam int IDX_W     = $clog2(PAL_ENTRIES);
  localparam int PAL_BYTES = PAL_ENTRIES * 3;
  localparam int PAL_AW    = $clog2(PAL_BYTES);
  localparam int CRT_SEL_W = $clog2(CRT_COUNT);

  logic [IDX_W-1:0]     rdIdx, wrIdx;
  logic [1:0]           subIdx;
  logic [7:0]           dacMode;
  logic [7:0]           crtIdx;
  logic [7:0]           crtFile [CRT_COUNT];
  logic [7:0]           palMem  [PAL_BYTES];

  logic [CRT_SEL_W-1:0] crtSel;
  logic                 crtIdxOk, lockOn;
  logic [7:0]           crtCur, crtNew;
  logic [PAL_AW-1:0]    rdAddr, wrAddr;
  logic                 lastSub;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(PAL_ENTRIES - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign crtSel   = crtIdx[CRT_SEL_W-1:0];
  assign crtIdxOk = ({24'd0, crtIdx} < 32'(CRT_COUNT));
  assign lockOn   = crtFile[LOCK_REG][LOCK_BIT];
  assign crtCur   = crtIdxOk ? crtFile[crtSel] : 8'h00;
  assign lastSub  = (subIdx == 2'd2);

  assign rdAddr = PAL_AW'(rdIdx) * PAL_AW'(3) + PAL_AW'(subIdx);
  assign wrAddr = PAL_AW'(wrIdx) * PAL_AW'(3) + PAL_AW'(subIdx);

  // value a data-port write leaves in the selected register
  always_comb begin
    crtNew = wdata;
    if (lockOn && (crtIdx <= 8'(PROT_LAST))) begin
      crtNew = crtCur;
      if (crtIdx == 8'(PROT_LAST)) crtNew[KEEP_BIT] = wdata[KEEP_BIT];
    end
  end

  // colour lookup state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx   <= '0;
      wrIdx   <= '0;
      subIdx  <= '0;
      dacMode <= '0;
    end else if (stb.loadRdIdx) begin
      rdIdx   <= wdata[IDX_W-1:0];
      subIdx  <= '0;
      dacMode <= MODE_READING;
    end else if (stb.loadWrIdx) begin
      wrIdx   <= wdata[IDX_W-1:0];
      subIdx  <= '0;
      dacMode <= MODE_WRITING;
    end else if (stb.palWr || stb.palRd) begin
      subIdx <= lastSub ? 2'd0 : subIdx + 2'd1;
      if (lastSub && stb.palWr) wrIdx <= stepIdx(wrIdx);
      if (lastSub && stb.palRd) rdIdx <= stepIdx(rdIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.palWr) palMem[wrAddr] <= wdata;
  end

  // CRT index and register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crtIdx <= '0;
      for (int i = 0; i < CRT_COUNT; i++) crtFile[i] <= '0;
    end else begin
      if (stb.crtIdxWr) crtIdx <= wdata;
      if (stb.crtDataWr && crtIdxOk) crtFile[crtSel] <= crtNew;
    end
  end

  for (genvar g = 0; g < CRT_COUNT; g++) begin : g_flat
    assign crtRegs[g*8 +: 8] = crtFile[g];
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_DAC_MODE: rdata = dacMode;
      RD_DAC_WIDX: rdata = 8'(wrIdx);
      RD_PAL:      rdata = palMem[rdAddr];
      RD_CRT_IDX:  rdata = crtIdx;
      RD_CRT_DATA: rdata = crtCur;
      default:     rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/disp_reg_port.sv
module disp_reg_port
  import disp_reg_port_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int CRT_COUNT   = 32,
  parameter int PAL_ENTRIES = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [7:0]             busWdata,
  output logic [7:0]             busRdata,
  output logic [CRT_COUNT*8-1:0] crtRegs
);

  strobes_t stb;

  disp_reg_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  disp_reg_port_dpath #(
    .CRT_COUNT   (CRT_COUNT),
    .PAL_ENTRIES (PAL_ENTRIES)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .crtRegs (crtRegs)
  );

endmodule

// File: rtl/disp_reg_port_chk.sv
module disp_reg_port_chk
  import disp_reg_port_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CRT_COUNT = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWr,
  input logic                   busRd,
  input logic [7:0]             busWdata,
  input logic [7:0]             busRdata,
  input logic [CRT_COUNT*8-1:0] crtRegs
);

  logic [7:0] shadowIdx;
  logic       lockOn, dataWr;

  always_ff @(posedge clk) begin
    if (!rstN) shadowIdx <= '0;
    else if (busWr && busAddr == ADDR_W'(PORT_CRT_IDX)) shadowIdx <= busWdata;
  end

  assign lockOn = crtRegs[LOCK_REG*8 + LOCK_BIT];
  assign dataWr = busWr && (busAddr == ADDR_W'(PORT_CRT_DATA));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (crtRegs == '0));

  p_idx_readback_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busAddr == ADDR_W'(PORT_CRT_IDX)) |-> (busRdata == shadowIdx));

  p_plain_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && ({24'd0, shadowIdx} < 32'(CRT_COUNT)) &&
     (!lockOn || shadowIdx > 8'(PROT_LAST)))
    |=> (crtRegs[int'($past(shadowIdx))*8 +: 8] == $past(busWdata)));

  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && lockOn && shadowIdx < 8'(PROT_LAST)) |=> $stable(crtRegs));

  p_locked_bit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && lockOn && shadowIdx == 8'(PROT_LAST))
    |=> (crtRegs[PROT_LAST*8 +: 8] ==
         {$past(crtRegs[PROT_LAST*8+5 +: 3]), $past(busWdata[KEEP_BIT]),
          $past(crtRegs[PROT_LAST*8 +: 4])}));

  p_out_of_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && ({24'd0, shadowIdx} >= 32'(CRT_COUNT))) |=> $stable(crtRegs));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == 8'h00));

endmodule

bind disp_reg_port disp_reg_port_chk #(
  .ADDR_W    (ADDR_W),
  .CRT_COUNT (CRT_COUNT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .crtRegs  (crtRegs)
);

// File: tb/disp_reg_port_tb_top.sv
module disp_reg_port_tb_top;

  localparam int ADDR_W    = 10;
  localparam int CRT_COUNT = 32;

  typedef struct packed {
    logic        isWr;
    logic [9:0]  addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 70;
  // W: write data; R: read and compare with exp
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'h3C7, 8'h00, 8'h00, 4'd2},  // R2 mode after reset
    '{1'b0, 10'h3C8, 8'h00, 8'h00, 4'd3},  // R3
    '{1'b0, 10'h3D5, 8'h00, 8'h00, 4'd1},  // R1
    '{1'b1, 10'h3C8, 8'h05, 8'h00, 4'd3},
    '{1'b0, 10'h3C8, 8'h00, 8'h05, 4'd3},  // R3 load
    '{1'b1, 10'h3C9, 8'h11, 8'h00, 4'd4},  // R4
    '{1'b1, 10'h3C9, 8'h22, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'h33, 8'h00, 4'd4},
    '{1'b0, 10'h3C8, 8'h00, 8'h06, 4'd3},  // R3 step
    '{1'b1, 10'h3C9, 8'h44, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'h55, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'h66, 8'h00, 4'd4},
    '{1'b1, 10'h3C7, 8'h05, 8'h00, 4'd2},
    '{1'b0, 10'h3C7, 8'h00, 8'h03, 4'd2},  // R2 reading mode
    '{1'b0, 10'h3C9, 8'h00, 8'h11, 4'd5},  // R5
    '{1'b0, 10'h3C9, 8'h00, 8'h22, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'h33, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'h44, 4'd5},  // R5 index stepped
    '{1'b0, 10'h3C9, 8'h00, 8'h55, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'h66, 4'd5},
    '{1'b1, 10'h3C8, 8'hFF, 8'h00, 4'd3},
    '{1'b0, 10'h3C7, 8'h00, 8'h00, 4'd2},  // R2 writing mode
    '{1'b1, 10'h3C9, 8'hA1, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'hA2, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'hA3, 8'h00, 4'd4},
    '{1'b0, 10'h3C8, 8'h00, 8'h00, 4'd3},  // R3 wrap
    '{1'b1, 10'h3C9, 8'h77, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'h78, 8'h00, 4'd4},
    '{1'b1, 10'h3C9, 8'h79, 8'h00, 4'd4},
    '{1'b1, 10'h3C7, 8'hFF, 8'h00, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'hA1, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'hA2, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'hA3, 4'd5},
    '{1'b0, 10'h3C9, 8'h00, 8'h77, 4'd5},  // R5 wrap
    '{1'b1, 10'h3D4, 8'h0A, 8'h00, 4'd6},
    '{1'b0, 10'h3D4, 8'h00, 8'h0A, 4'd6},  // R6
    '{1'b1, 10'h3D5, 8'h5C, 8'h00, 4'd7},
    '{1'b0, 10'h3D5, 8'h00, 8'h5C, 4'd7},  // R7
    '{1'b1, 10'h3D4, 8'h03, 8'h00, 4'd7},
    '{1'b1, 10'h3D5, 8'hC3, 8'h00, 4'd7},
    '{1'b0, 10'h3D5, 8'h00, 8'hC3, 4'd7},  // R7 unlocked low reg
    '{1'b1, 10'h3D4, 8'h07, 8'h00, 4'd7},
    '{1'b1, 10'h3D5, 8'hFF, 8'h00, 4'd7},
    '{1'b1, 10'h3D4, 8'h11, 8'h00, 4'd7},
    '{1'b1, 10'h3D5, 8'h80, 8'h00, 4'd7},
    '{1'b0, 10'h3D5, 8'h00, 8'h80, 4'd7},
    '{1'b1, 10'h3D4, 8'h03, 8'h00, 4'd8},
    '{1'b1, 10'h3D5, 8'h12, 8'h00, 4'd8},
    '{1'b0, 10'h3D5, 8'h00, 8'hC3, 4'd8},  // R8 locked
    '{1'b1, 10'h3D4, 8'h07, 8'h00, 4'd9},
    '{1'b1, 10'h3D5, 8'h00, 8'h00, 4'd9},
    '{1'b0, 10'h3D5, 8'h00, 8'hEF, 4'd9},  // R9 bit4 cleared only
    '{1'b1, 10'h3D5, 8'h10, 8'h00, 4'd9},
    '{1'b0, 10'h3D5, 8'h00, 8'hFF, 4'd9},  // R9 bit4 set only
    '{1'b1, 10'h3D4, 8'h08, 8'h00, 4'd7},
    '{1'b1, 10'h3D5, 8'h9A, 8'h00, 4'd7},
    '{1'b0, 10'h3D5, 8'h00, 8'h9A, 4'd7},  // R7 above range
    '{1'b1, 10'h3D4, 8'h30, 8'h00, 4'd10},
    '{1'b1, 10'h3D5, 8'h55, 8'h00, 4'd10},
    '{1'b0, 10'h3D5, 8'h00, 8'h00, 4'd10}, // R10
    '{1'b0, 10'h3D4, 8'h00, 8'h30, 4'd6},
    '{1'b1, 10'h3D4, 8'h11, 8'h00, 4'd8},
    '{1'b1, 10'h3D5, 8'h00, 8'h00, 4'd8},
    '{1'b1, 10'h3D4, 8'h03, 8'h00, 4'd8},
    '{1'b1, 10'h3D5, 8'h12, 8'h00, 4'd8},
    '{1'b0, 10'h3D5, 8'h00, 8'h12, 4'd8},  // R8 unlocked again
    '{1'b1, 10'h3C0, 8'hFF, 8'h00, 4'd12},
    '{1'b0, 10'h3C0, 8'h00, 8'h00, 4'd12}, // R12
    '{1'b0, 10'h3C8, 8'h00, 8'h01, 4'd12},
    '{1'b0, 10'h3D5, 8'h00, 8'h12, 4'd12}
  };

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [ADDR_W-1:0]      busAddr;
  logic                   busWr, busRd;
  logic [7:0]             busWdata;
  logic [7:0]             busRdata;
  logic [CRT_COUNT*8-1:0] crtRegs;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  disp_reg_port dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .crtRegs  (crtRegs)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input int req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic isWr, input logic [9:0] addr,
                        input logic [7:0] data, input logic [7:0] exp, input int req);
    @(negedge clk);
    busAddr  = addr;
    busWr    = isWr;
    busRd    = !isWr;
    busWdata = data;
    #1;
    if (!isWr) check(busRdata, exp, req, $sformatf("read %03h", addr));
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    busWr = 1'b0;
    busRd = 1'b0;
    busAddr = '0;
  endtask

  initial begin
    rstN = 1'b0;
    busAddr = '0;
    busWr = 1'b0;
    busRd = 1'b0;
    busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(crtRegs[7:0], 8'h00, 1, "R1 crt reg 0 after reset");

    for (int i = 0; i < NVEC; i++)
      access(VECS[i].isWr, VECS[i].addr, VECS[i].data, VECS[i].exp, int'(VECS[i].req));
    idle();

    // R11 flattened register output
    check(crtRegs[3*8 +: 8],    8'h12, 11, "R11 reg 3 on crtRegs");
    check(crtRegs[7*8 +: 8],    8'hFF, 11, "R11 reg 7 on crtRegs");
    check(crtRegs[8*8 +: 8],    8'h9A, 11, "R11 reg 8 on crtRegs");
    check(crtRegs[10*8 +: 8],   8'h5C, 11, "R11 reg 10 on crtRegs");
    check(crtRegs['h11*8 +: 8], 8'h00, 11, "R11 reg 0x11 on crtRegs");

    // R12 read strobe low gives zero
    @(negedge clk);
    busAddr = 10'h3D5;
    #1;
    check(busRdata, 8'h00, 12, "R12 no strobe");

    // R1 reset clears everything
    idle();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check((crtRegs == '0) ? 8'h00 : 8'h01, 8'h00, 1, "R1 crtRegs zero");
    access(1'b0, 10'h3C8, 8'h00, 8'h00, 1);  // R1 write index
    access(1'b0, 10'h3D4, 8'h00, 8'h00, 1);  // R1 crt index
    access(1'b0, 10'h3C7, 8'h00, 8'h00, 1);  // R1 mode
    idle();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule